// File: doc/BRIEF.md
# Cartridge Guard and Bank Mapper

This block sits on a cartridge, between the system processor's 8-bit bus and a flat ROM. After reset it keeps the ROM hidden. The processor must first clock a bit-serial key into the cartridge by writing to address 6000h. Each key character takes nine writes: eight data bits, most significant first, followed by one zero bit. The message has fifteen characters. The block counts these writes and does not check their values. After the key, the block answers on the next eight reads of 6000h with a fixed byte, one bit per read on data lane 1, most significant bit first. Once the answer has been read out, the ROM is enabled.

With the ROM open, the processor window 6000h–DFFFh is moved down to ROM address zero. The window splits into two 16 KiB halves, and a parameter selects one of three variants. The flat variant maps the window directly with no banking. The banked variant fixes the lower half to ROM bank 0 and takes the upper half's bank from writes to C000h–DFFFh. The dual variant also takes the lower half's bank from writes to 8000h–9FFFh. Every access is a single-cycle strobe. Outputs are combinational on the current access, and state changes at the clock edge that ends it.

Top module: `cart_guard_mapper`

## Requirements
- R1: After a synchronous active-low reset the block is locked with all counters cleared: no ROM select and no reply drive for any access, and every bank register reads back as 0 once the block is opened again.
- R2: While locked, only writes to exactly 6000h advance the key count. Reads, and writes to any other address, neither advance it nor select the ROM. After 134 key writes, a read of 6000h still gives no reply.
- R3: After the 135th key write, each read of 6000h drives reply_oe high. reply_data bit 1 carries the next bit of 47h, most significant first, and all other bits of reply_data are 0.
- R4: During the reply phase, writes to 6000h and reads of other addresses do not advance the reply and produce neither reply drive nor ROM select.
- R5: After the eighth reply read, reads in 6000h–DFFFh assert rom_cs and reads outside that window do not. reply_oe stays low, and writes never assert rom_cs.
- R6: The window is flattened so that 6000h maps to ROM address 0000h and 7000h maps to 1000h.
- R7: In the banked variant, 6000h–9FFFh always maps into ROM bank 0 (ROM address = offset from 6000h).
- R8: In the banked and dual variants, A000h–DFFFh maps to bank*4000h + (offset mod 4000h). The bank is loaded by a write to C000h–DFFFh with the written byte modulo the number of banks.
- R9: In the dual variant, a write to 8000h–9FFFh loads the bank for 6000h–9FFFh (byte modulo the number of banks). In the banked variant such a write has no effect.
- R10: In the flat variant, ROM address = CPU address − 6000h for the whole window, and bank writes have no effect.
- R11: The data value of a key write has no effect on the unlock sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_valid | input | 1 | One-cycle strobe marking a processor access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 16 | Processor address |
| bus_wdata | input | 8 | Processor write data |
| rom_cs | output | 1 | ROM read select, active high |
| rom_addr | output | ROM_AW (17 by default) | Flattened ROM address |
| reply_oe | output | 1 | Block drives the data bus with the reply |
| reply_data | output | 8 | Reply byte; only bit 1 carries data |

## Verification
The assertions assume that each processor access is one clean strobe of bus_valid, with address, direction and data held steady for that cycle, and that reset is applied before the first access. The stimulus drives every access as a single-cycle strobe set up on the falling edge. It then samples the combinational outputs before the committing rising edge. Random addresses stay in 5000h–FFFFh and cover both halves of the window, the bank-register ranges and the space outside the window. Directed cases cover the last key write, the interleaved writes and reads in the reply phase, and bank values that wrap.

// File: rtl/cart_pkg.sv
// Shared types and constants for the cartridge guard and mapper.
// Assumes a 16-bit processor address space with the window at 6000h-DFFFh.
package cart_pkg;
    // Unlock progress: collecting key writes, serving reply reads, open.
    typedef enum logic [1:0] {
        PH_COLLECT = 2'd0,
        PH_REPLY   = 2'd1,
        PH_OPEN    = 2'd2
    } guard_phase_t;

    // Mapper variants chosen by parameter.
    localparam int MAP_FLAT = 0;
    localparam int MAP_BANK = 1;
    localparam int MAP_DUAL = 2;

    localparam logic [15:0] WIN_LO     = 16'h6000;
    localparam logic [15:0] WIN_HI     = 16'hDFFF;
    localparam logic [15:0] KEY_ADDR   = 16'h6000;
    localparam int          REPLY_LANE = 1;
endpackage

// File: rtl/cart_unlock_seq.sv
// Unlock sequencer: counts key writes, then counts reply reads, then opens.
// Assumes key_wr and key_rd are single-cycle, mutually exclusive strobes.
module cart_unlock_seq
    import cart_pkg::*;
#(
    parameter int CHARS         = 15,
    parameter int BITS_PER_CHAR = 9,
    parameter int REPLY_BITS    = 8,
    localparam int TOTAL  = CHARS * BITS_PER_CHAR,
    localparam int WCNT_W = $clog2(TOTAL + 1),
    localparam int RCNT_W = $clog2(REPLY_BITS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              key_wr,
    input  logic              key_rd,
    output guard_phase_t      phase,
    output logic [RCNT_W-1:0] reply_idx
);
    logic [WCNT_W-1:0] wr_cnt;
    logic [RCNT_W-1:0] rd_cnt;

    // Advance the phase and its counters on key accesses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase  <= PH_COLLECT;
            wr_cnt <= '0;
            rd_cnt <= '0;
        end else begin
            case (phase)
                PH_COLLECT: if (key_wr) begin
                    if (wr_cnt == WCNT_W'(TOTAL - 1)) begin
                        phase  <= PH_REPLY;
                        wr_cnt <= '0;
                    end else begin
                        wr_cnt <= wr_cnt + 1'b1;
                    end
                end
                PH_REPLY: if (key_rd) begin
                    if (rd_cnt == RCNT_W'(REPLY_BITS - 1)) begin
                        phase <= PH_OPEN;
                    end else begin
                        rd_cnt <= rd_cnt + 1'b1;
                    end
                end
                default: phase <= PH_OPEN;
            endcase
        end
    end

    assign reply_idx = rd_cnt;

    // R2: the key count never reaches the full length while collecting.
    p_wrcnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cnt < WCNT_W'(TOTAL));

    // R5: once open, the block stays open until reset.
    p_open_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        phase == PH_OPEN |=> phase == PH_OPEN);

    // R4: without a key access no progress state moves.
    p_idle_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(key_wr || key_rd) |=> ($stable(phase) && $stable(wr_cnt) && $stable(rd_cnt)));

    // R3: each reply read steps the reply position by one or opens the ROM.
    p_reply_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_REPLY && key_rd) |=>
            (phase == PH_OPEN || 32'(reply_idx) == 32'($past(reply_idx)) + 1));
endmodule

// File: rtl/cart_bank_regs.sv
// Bank registers: hold the 16 KiB bank numbers for the two window halves.
// Assumes addr_top is bus address bits 15:13 and wr_en is a write strobe.
module cart_bank_regs
    import cart_pkg::*;
#(
    parameter int MAP_KIND  = MAP_BANK,
    parameter int ROM_BANKS = 6,
    parameter int BANK_W    = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [2:0]        addr_top,
    input  logic [7:0]        wdata,
    output logic [BANK_W-1:0] lo_bank,
    output logic [BANK_W-1:0] hi_bank
);
    // Reduce a written byte to a valid bank number.
    function automatic logic [BANK_W-1:0] fold(input logic [7:0] v);
        return BANK_W'(int'(v) % ROM_BANKS);
    endfunction

    generate
        if (MAP_KIND == MAP_FLAT) begin : g_flat
            assign lo_bank = '0;
            assign hi_bank = '0;
        end else begin : g_switch
            logic [BANK_W-1:0] hi_q;

            // Load the upper-half bank on writes to C000h-DFFFh.
            always_ff @(posedge clk) begin
                if (!rst_n)                          hi_q <= '0;
                else if (wr_en && addr_top == 3'b110) hi_q <= fold(wdata);
            end
            assign hi_bank = hi_q;

            // R8: the upper bank is always a valid bank number.
            p_hi_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
                32'(hi_q) < ROM_BANKS);

            if (MAP_KIND == MAP_DUAL) begin : g_dual
                logic [BANK_W-1:0] lo_q;

                // Load the lower-half bank on writes to 8000h-9FFFh.
                always_ff @(posedge clk) begin
                    if (!rst_n)                          lo_q <= '0;
                    else if (wr_en && addr_top == 3'b100) lo_q <= fold(wdata);
                end
                assign lo_bank = lo_q;

                // R9: the lower bank is always a valid bank number.
                p_lo_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
                    32'(lo_q) < ROM_BANKS);

                // R9: the lower bank only moves on a write into its range.
                p_lo_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
                    !(wr_en && addr_top == 3'b100) |=> $stable(lo_q));
            end else begin : g_fixed
                assign lo_bank = '0;
            end
        end
    endgenerate
endmodule

// File: rtl/cart_addr_map.sv
// Address flattener: turns a window address into a ROM address.
// Assumes ROM_AW = BANK_W + 14; the result is meaningful only inside the window.
module cart_addr_map
    import cart_pkg::*;
#(
    parameter int MAP_KIND = MAP_BANK,
    parameter int BANK_W   = 3,
    parameter int ROM_AW   = 17
) (
    input  logic [15:0]       addr,
    input  logic [BANK_W-1:0] lo_bank,
    input  logic [BANK_W-1:0] hi_bank,
    output logic              in_window,
    output logic [ROM_AW-1:0] rom_addr
);
    logic [14:0] off;

    // Offset from the window base; wraps correctly across 8000h.
    assign off       = addr[14:0] - 15'h6000;
    assign in_window = (addr >= WIN_LO) && (addr <= WIN_HI);

    generate
        if (MAP_KIND == MAP_FLAT) begin : g_flat
            assign rom_addr = ROM_AW'(off);
        end else begin : g_banked
            logic [BANK_W-1:0] sel;
            // Bit 14 of the offset picks the window half.
            assign sel      = off[14] ? hi_bank : lo_bank;
            assign rom_addr = {sel, off[13:0]};
        end
    endgenerate
endmodule

// File: rtl/cart_guard_mapper.sv
// Top: cartridge guard (serial key, serial reply) and window bank mapper.
// Assumes single-cycle access strobes; outputs are combinational on the
// current access and state commits at the clock edge ending it.
module cart_guard_mapper
    import cart_pkg::*;
#(
    parameter int MAP_KIND                  = MAP_BANK,
    parameter int ROM_BANKS                 = 6,
    parameter int CHARS                     = 15,
    parameter int BITS_PER_CHAR             = 9,
    parameter int REPLY_BITS                = 8,
    parameter logic [REPLY_BITS-1:0] REPLY_WORD = 8'h47,
    localparam int BANK_W = (ROM_BANKS > 1) ? $clog2(ROM_BANKS) : 1,
    localparam int ROM_AW = BANK_W + 14,
    localparam int RCNT_W = $clog2(REPLY_BITS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_we,
    input  logic [15:0]       bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic              rom_cs,
    output logic [ROM_AW-1:0] rom_addr,
    output logic              reply_oe,
    output logic [7:0]        reply_data
);
    guard_phase_t              phase;
    logic [RCNT_W-1:0]         reply_idx;
    logic                      key_hit, key_wr, key_rd;
    logic [BANK_W-1:0]         lo_bank, hi_bank;
    logic                      in_window;
    logic [REPLY_BITS-1:0]     reply_shift;
    logic                      reply_bit;

    // Decode accesses to the key address.
    assign key_hit = bus_valid && (bus_addr == KEY_ADDR);
    assign key_wr  = key_hit && bus_we;
    assign key_rd  = key_hit && !bus_we;

    cart_unlock_seq #(
        .CHARS         (CHARS),
        .BITS_PER_CHAR (BITS_PER_CHAR),
        .REPLY_BITS    (REPLY_BITS)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .key_wr    (key_wr),
        .key_rd    (key_rd),
        .phase     (phase),
        .reply_idx (reply_idx)
    );

    cart_bank_regs #(
        .MAP_KIND  (MAP_KIND),
        .ROM_BANKS (ROM_BANKS),
        .BANK_W    (BANK_W)
    ) u_banks (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (bus_valid && bus_we),
        .addr_top (bus_addr[15:13]),
        .wdata    (bus_wdata),
        .lo_bank  (lo_bank),
        .hi_bank  (hi_bank)
    );

    cart_addr_map #(
        .MAP_KIND (MAP_KIND),
        .BANK_W   (BANK_W),
        .ROM_AW   (ROM_AW)
    ) u_map (
        .addr      (bus_addr),
        .lo_bank   (lo_bank),
        .hi_bank   (hi_bank),
        .in_window (in_window),
        .rom_addr  (rom_addr)
    );

    // ROM select: reads inside the window once the guard has opened.
    assign rom_cs = bus_valid && !bus_we && in_window && (phase == PH_OPEN);

    // Reply bit: reply word bits taken most significant first.
    assign reply_shift = REPLY_WORD << reply_idx;
    assign reply_bit   = reply_shift[REPLY_BITS-1];
    assign reply_oe    = key_rd && (phase == PH_REPLY);

    // Place the reply bit on its data lane; every other lane reads 0.
    always_comb begin
        reply_data             = '0;
        reply_data[REPLY_LANE] = reply_oe && reply_bit;
    end

    // R5: the ROM and the reply never drive the same access.
    p_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(rom_cs && reply_oe));

    // R3: lanes other than the reply lane stay 0.
    p_reply_lanes_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (reply_data & ~(8'h01 << REPLY_LANE)) == 8'h00);

    // R6: a selected ROM address lies inside the ROM.
    p_cs_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rom_cs |-> 32'(rom_addr) < ROM_BANKS * 16384);

    // R2: a non-key access while collecting leaves the guard collecting.
    p_collect_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_COLLECT && !key_wr) |=> phase == PH_COLLECT);
endmodule

// File: tb/sim_cart_guard_mapper.sv
// Bench: three variants on one shared bus, directed and seeded random accesses.
module sim_cart_guard_mapper;
    import cart_pkg::*;

    localparam int NB = 6;
    localparam int AW = 17;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0;
    logic        bus_we = 1'b0;
    logic [15:0] bus_addr = 16'h0000;
    logic [7:0]  bus_wdata = 8'h00;

    logic          cs0, cs1, cs2, oe0, oe1, oe2;
    logic [AW-1:0] a0, a1, a2;
    logic [7:0]    d0, d1, d2;

    int total = 0;
    int bad = 0;
    bit done = 0;
    int lo1, hi0, hi1;
    bit opened;

    always #4 clk = ~clk;

    cart_guard_mapper #(.MAP_KIND(MAP_BANK), .ROM_BANKS(NB)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .rom_cs(cs0),
        .rom_addr(a0), .reply_oe(oe0), .reply_data(d0));

    cart_guard_mapper #(.MAP_KIND(MAP_DUAL), .ROM_BANKS(NB)) u1 (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .rom_cs(cs1),
        .rom_addr(a1), .reply_oe(oe1), .reply_data(d1));

    cart_guard_mapper #(.MAP_KIND(MAP_FLAT), .ROM_BANKS(NB)) u2 (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .rom_cs(cs2),
        .rom_addr(a2), .reply_oe(oe2), .reply_data(d2));

    // Count one check and report a mismatch.
    task automatic check(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    // Expected ROM address from the mapping requirements.
    function automatic int exp_addr(input int kind, input logic [15:0] a,
                                    input int lo, input int hi);
        int off;
        int bank;
        off = int'(a) - 'h6000;
        if (kind == MAP_FLAT) return off;
        bank = (off < 'h4000) ? lo : hi;
        return bank * 16384 + (off % 16384);
    endfunction

    // Drive one access on the falling edge; outputs settle before the rise.
    task automatic op(input bit we, input logic [15:0] a, input logic [7:0] d = 8'h00);
        @(negedge clk);
        bus_valid = 1'b1;
        bus_we    = we;
        bus_addr  = a;
        bus_wdata = d;
        #1;
        if (we && a[15:13] == 3'b110) begin
            hi0 = int'(d) % NB;
            hi1 = int'(d) % NB;
        end
        if (we && a[15:13] == 3'b100) lo1 = int'(d) % NB;
    endtask

    task automatic idle();
        @(negedge clk);
        bus_valid = 1'b0;
        bus_we    = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        bus_valid = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        lo1 = 0; hi0 = 0; hi1 = 0; opened = 0;
    endtask

    // Check all three variants against the model for the current access.
    task automatic check_map();
        bit inw;
        bit ecs;
        string t0, t1, t2;
        inw = (bus_addr >= 16'h6000) && (bus_addr <= 16'hDFFF);
        ecs = opened && inw && !bus_we;
        t0 = !inw ? "R5" : (bus_addr < 16'hA000 ? "R7" : "R8");
        t1 = inw ? "R9" : "R5";
        t2 = inw ? "R10" : "R5";
        check({t0, " u0 rom_cs"}, int'(cs0), int'(ecs));
        check({t1, " u1 rom_cs"}, int'(cs1), int'(ecs));
        check({t2, " u2 rom_cs"}, int'(cs2), int'(ecs));
        if (ecs) begin
            check({t0, " u0 rom_addr"}, int'(a0), exp_addr(MAP_BANK, bus_addr, 0, hi0));
            check({t1, " u1 rom_addr"}, int'(a1), exp_addr(MAP_DUAL, bus_addr, lo1, hi1));
            check({t2, " u2 rom_addr"}, int'(a2), exp_addr(MAP_FLAT, bus_addr, 0, 0));
        end
        if (opened) check("R5 reply_oe after open", int'(oe0 | oe1 | oe2), 0);
    endtask

    // Key phase (R2, R11: random key data) then reply phase (R3, R4).
    task automatic unlock();
        for (int i = 0; i < 135; i++) begin
            if (i == 134) begin
                op(0, 16'h6000);
                check("R2 reply before last key write", int'(oe0 | oe1 | oe2), 0);
            end
            op(1, 16'h6000, 8'($urandom));
            if (i % 9 == 4) begin
                op(0, 16'h6000 + 16'($urandom % 32'h8000));
                check("R2 locked rom_cs", int'(cs0 | cs1 | cs2), 0);
                check("R2 locked reply_oe", int'(oe0 | oe1 | oe2), 0);
                op(1, 16'h6001, 8'($urandom));
            end
        end
        for (int k = 0; k < 8; k++) begin
            if (k == 3) begin
                op(1, 16'h6000, 8'hFF);
                op(0, 16'h7000);
                check("R4 reply stall oe", int'(oe0 | oe1 | oe2), 0);
                check("R4 reply stall cs", int'(cs0 | cs1 | cs2), 0);
            end
            op(0, 16'h6000);
            check("R3 u0 reply_oe", int'(oe0), 1);
            check("R3 u1 reply_oe", int'(oe1), 1);
            check("R3 u2 reply_oe", int'(oe2), 1);
            check("R3/R11 u0 reply_data", int'(d0), ((8'h47 >> (7 - k)) & 1) << 1);
            check("R3 u1 reply_data", int'(d1), ((8'h47 >> (7 - k)) & 1) << 1);
            check("R3 u2 reply_data", int'(d2), ((8'h47 >> (7 - k)) & 1) << 1);
            check("R3 no rom_cs in reply", int'(cs0 | cs1 | cs2), 0);
        end
        opened = 1;
    endtask

    initial begin
        void'($urandom(32'd5521));
        do_reset();
        // R1: locked after reset.
        op(0, 16'h6000);
        check("R1 reset reply_oe", int'(oe0 | oe1 | oe2), 0);
        check("R1 reset rom_cs", int'(cs0 | cs1 | cs2), 0);
        op(0, 16'hA000);
        check("R1 reset rom_cs upper", int'(cs0 | cs1 | cs2), 0);

        unlock();

        // R5/R6: ROM open, flattened addresses.
        op(0, 16'h6000);
        check("R5 open rom_cs", int'(cs0 & cs1 & cs2), 1);
        check("R6 6000h flat", int'(a2), 'h0000);
        check("R6 6000h banked", int'(a0), 'h0000);
        op(0, 16'h7000);
        check("R6 7000h flat", int'(a2), 'h1000);
        check("R7 7000h banked", int'(a0), 'h1000);
        op(0, 16'hA000);
        check("R1 upper bank reset u0", int'(a0), 'h0000);
        check("R1 upper bank reset u1", int'(a1), 'h0000);
        check("R10 A000h flat", int'(a2), 'h4000);
        op(0, 16'h5FFF); check_map();
        op(0, 16'hE000); check_map();
        op(1, 16'h7000, 8'h12);
        check("R5 write no rom_cs", int'(cs0 | cs1 | cs2), 0);

        // R8: upper bank with modulo wrap.
        op(1, 16'hC000, 8'h07);
        op(0, 16'hA123);
        check("R8 bank 7 wraps to 1", int'(a0), 16384 + 'h0123);
        check("R10 flat ignores bank", int'(a2), 'h4123);
        op(1, 16'hDFFF, 8'hFF);
        op(0, 16'hDFFF);
        check("R8 bank FFh wraps to 3", int'(a0), 3 * 16384 + 'h3FFF);
        // R9: lower bank only in the dual variant.
        op(1, 16'h8000, 8'h05);
        op(0, 16'h6010);
        check("R9 dual lower bank", int'(a1), 5 * 16384 + 'h10);
        check("R9 banked ignores lower write", int'(a0), 'h10);
        check("R10 flat 6010h", int'(a2), 'h10);

        // Seeded random accesses across 5000h-FFFFh.
        for (int n = 0; n < 400; n++) begin
            bit we;
            logic [15:0] a;
            we = ($urandom % 3) == 0;
            a  = 16'h5000 + 16'($urandom % 32'hB000);
            op(we, a, 8'($urandom));
            check_map();
        end

        // R1: a second reset relocks and clears the banks.
        do_reset();
        op(0, 16'h6000);
        check("R1 relock rom_cs", int'(cs0 | cs1 | cs2), 0);
        check("R1 relock reply_oe", int'(oe0 | oe1 | oe2), 0);
        unlock();
        op(0, 16'hA000); check_map();
        op(0, 16'h9FFF); check_map();
        idle();

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog act=hung exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule